// File: doc/BRIEF.md
# Preloaded PWM Output Generator

This block is one edge-aligned PWM channel. A 16-bit up-counter runs from zero to a programmable period value and then returns to zero. A programmable clock divider sets how often the counter steps. The pin is in its active state while the count is below a compare value, so the period value sets the frequency and the compare value sets the duty cycle.

Software sets it up through a single-cycle write port with four word addresses. The period and the compare value can each be written straight into the working copy, or held in a shadow that is copied across at the next wrap. The divider value is always held in a shadow. The polarity and the output enable are separate control bits. Besides the pin, the block gives a one-cycle pulse at each wrap and a one-cycle pulse when the counter steps onto the compare value.

Top module: `pwm_chan`

## Requirements
- R1: While `rst_ni` is low, `pwm_o`, `update_o` and `match_o` are 0, and every register (control, period, compare, divider, their shadows and the counter) is cleared.
- R2: With divider value 0 and working period P, the counter steps once per clock through 0..P and back to 0, so `update_o` pulses every P+1 clocks. If the working period falls below the current count, the next step wraps to 0.
- R3: With output enabled and polarity 0, `pwm_o` is 1 exactly while count < working compare value C. Over one period it is high for C counter steps when C <= P+1.
- R4: C = 0 keeps `pwm_o` at the inactive level for the whole period. C > P keeps it at the active level for the whole period.
- R5: Control bit 2 (polarity) inverts the active level. When control bit 3 (output enable) is 0, `pwm_o` equals the polarity bit. Control is written at address 0, bits [3:0].
- R6: The divider value N is written at address 3. It takes effect at the next wrap, after which the counter steps once every N+1 clocks. A period then lasts (P+1)(N+1) clocks.
- R7: Compare is written at address 2. With control bit 0 set, the write goes only to the shadow and reaches the working compare at the next wrap. With bit 0 clear, it takes effect on the next clock.
- R8: Period is written at address 1. With control bit 1 set, the write goes only to the shadow and reaches the working period at the next wrap. With bit 1 clear, it takes effect on the next clock.
- R9: `update_o` is high for exactly one clock, the first clock in which the counter is 0 after a wrap.
- R10: `match_o` is high for exactly one clock, the first clock after a counter step in which the count equals the working compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 period, 2 compare, 3 divider |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 1 | PWM pin |
| update_o | output | 1 | Wrap pulse |
| match_o | output | 1 | Compare-match pulse |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a period, together with a wrap that coincides with a shadow write. Only there does buffered behaviour differ from immediate behaviour. Directed sequences wait for an update pulse and count a known number of clocks to put the counter at a chosen value. They then write a new compare or period and watch the pin and the time to the next wrap, once with buffering on and once with it off. A long seeded random phase then issues frequent writes with small periods and divider values. This makes writes fall on wrap clocks often, and every output is compared on every clock against a bench model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_PERIOD  = 2'd1,
    REG_COMPARE = 2'd2,
    REG_PRESC   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic out_en;
    logic pol;
    logic per_pre;
    logic cmp_pre;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              upd_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  per_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [PSC_W-1:0]  psc_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_sh, per_act, cmp_sh, cmp_act;
  logic [PSC_W-1:0] psc_sh, psc_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      per_sh  <= '0;
      per_act <= '0;
      cmp_sh  <= '0;
      cmp_act <= '0;
      psc_sh  <= '0;
      psc_act <= '0;
    end else begin
      if (upd_i) begin
        per_act <= per_sh;
        cmp_act <= cmp_sh;
        psc_act <= psc_sh;
      end
      // immediate writes override the update load
      if (wr_en_i) begin
        unique case (reg_addr_e'(wr_addr_i))
          REG_CTRL: ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
          REG_PERIOD: begin
            per_sh <= wr_data_i[CNT_W-1:0];
            if (!ctrl_q.per_pre) per_act <= wr_data_i[CNT_W-1:0];
          end
          REG_COMPARE: begin
            cmp_sh <= wr_data_i[CNT_W-1:0];
            if (!ctrl_q.cmp_pre) cmp_act <= wr_data_i[CNT_W-1:0];
          end
          REG_PRESC: psc_sh <= wr_data_i[PSC_W-1:0];
        endcase
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign per_o  = per_act;
  assign cmp_o  = cmp_act;
  assign psc_o  = psc_act;

  AST_CMP_PRELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.cmp_pre && !upd_i) |=> $stable(cmp_act)); // R7
  AST_PER_PRELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.per_pre && !upd_i) |=> $stable(per_act)); // R8
endmodule

// File: rtl/pwm_presc.sv
module pwm_presc #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  assign tick_o = (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  AST_PSC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= psc_i); // R6
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             step_o,
  output logic             update_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step_q, wrap_q;

  // >= so a period shrunk below the count wraps on the next step
  assign wrap_o = tick_i && (cnt_q >= per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      step_q <= tick_i;
      wrap_q <= wrap_o;
      if (wrap_o)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign step_o   = step_q;
  assign update_o = step_q && wrap_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R6
  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q < per_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_UPD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (cnt_q == '0)); // R9
endmodule

// File: rtl/pwm_out.sv
module pwm_out
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  ctrl_t            ctrl_i,
  input  logic             step_i,
  output logic             pwm_o,
  output logic             match_o
);
  logic active;

  assign active  = (cnt_i < cmp_i);
  assign pwm_o   = ctrl_i.out_en ? (active ^ ctrl_i.pol) : ctrl_i.pol;
  assign match_o = step_i && (cnt_i == cmp_i);

  AST_MATCH_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (pwm_o == ctrl_i.pol)); // R10
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  localparam int unsigned DATA_W = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              update_o,
  output logic              match_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] per, cmp, cnt;
  logic [PSC_W-1:0] psc;
  logic             tick, wrap, step;

  pwm_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .upd_i(wrap), .ctrl_o(ctrl), .per_o(per), .cmp_o(cmp), .psc_o(psc)
  );

  pwm_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i, .rst_ni, .psc_i(psc), .tick_o(tick)
  );

  pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .per_i(per),
    .cnt_o(cnt), .wrap_o(wrap), .step_o(step), .update_o(update_o)
  );

  pwm_out #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .cnt_i(cnt), .cmp_i(cmp), .ctrl_i(ctrl),
    .step_i(step), .pwm_o(pwm_o), .match_o(match_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o && !match_o) |-> (cmp != '0)); // R10
endmodule

// File: tb/tb_pwm_chan.sv
`timescale 1ns/1ps
module tb_pwm_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm, upd, mtc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [3:0]  m_ctrl;
  logic [15:0] m_per_sh, m_per, m_cmp_sh, m_cmp, m_psc_sh, m_psc, m_pc, m_cnt;
  logic        m_step, m_wrap;

  always #2.5 clk = ~clk;

  pwm_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .update_o(upd), .match_o(mtc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_per_sh = '0; m_per = '0; m_cmp_sh = '0; m_cmp = '0;
    m_psc_sh = '0; m_psc = '0; m_pc = '0; m_cnt = '0; m_step = 0; m_wrap = 0;
  endtask

  task automatic model_step(input logic we, input logic [1:0] a, input logic [15:0] d);
    logic tk, wr;
    tk = (m_pc >= m_psc);
    wr = tk && (m_cnt >= m_per);
    m_pc = tk ? 16'd0 : m_pc + 16'd1;
    if (tk) m_cnt = wr ? 16'd0 : m_cnt + 16'd1;
    m_step = tk;
    m_wrap = wr;
    if (wr) begin m_per = m_per_sh; m_cmp = m_cmp_sh; m_psc = m_psc_sh; end
    if (we) begin
      case (a)
        2'd0: m_ctrl = d[3:0];
        2'd1: begin m_per_sh = d; if (!m_ctrl[1]) m_per = d; end
        2'd2: begin m_cmp_sh = d; if (!m_ctrl[0]) m_cmp = d; end
        default: m_psc_sh = d;
      endcase
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d);
    logic e_pwm;
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_step(we, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    e_pwm = m_ctrl[3] ? ((m_cnt < m_cmp) ^ m_ctrl[2]) : m_ctrl[2];
    chk("R3 pwm_o", int'(pwm), int'(e_pwm));
    chk("R9 update_o", int'(upd), int'(m_step && m_wrap));
    chk("R10 match_o", int'(mtc), int'(m_step && (m_cnt == m_cmp)));
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'd0);
  endtask

  task automatic wait_upd();
    int guard = 0;
    do begin
      cyc(1'b0, 2'd0, 16'd0);
      guard++;
    end while (!upd && guard < 5000);
  endtask

  task automatic measure(output int len, output int hi);
    int guard = 0;
    wait_upd();
    len = 0; hi = 0;
    do begin
      len++;
      hi += int'(pwm);
      cyc(1'b0, 2'd0, 16'd0);
      guard++;
    end while (!upd && guard < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, hi, k;
    void'($urandom(32'd20121));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 pwm_o in reset", int'(pwm), 0);
    chk("R1 update_o in reset", int'(upd), 0);
    chk("R1 match_o in reset", int'(mtc), 0);
    rst_n = 1'b1;

    // basic PWM, P=9 C=4
    wr(2'd3, 16'd0); wr(2'd1, 16'd9); wr(2'd2, 16'd4); wr(2'd0, 16'b1000);
    measure(len, hi);
    chk("R2 period length", len, 10);
    chk("R3 high time", hi, 4);
    wr(2'd2, 16'd0);
    measure(len, hi);
    chk("R4 compare zero", hi, 0);
    wr(2'd2, 16'd12);
    measure(len, hi);
    chk("R4 compare above period", hi, 10);

    // polarity and enable
    wr(2'd2, 16'd4); wr(2'd0, 16'b1100);
    measure(len, hi);
    chk("R5 inverted high time", hi, 6);
    wr(2'd0, 16'b0100);
    measure(len, hi);
    chk("R5 disabled pin inverted", hi, 10);
    wr(2'd0, 16'b0000);
    measure(len, hi);
    chk("R5 disabled pin normal", hi, 0);

    // prescaler
    wr(2'd0, 16'b1000); wr(2'd3, 16'd2);
    measure(len, hi);
    chk("R6 prescaled period", len, 30);
    chk("R6 prescaled high", hi, 12);
    wr(2'd3, 16'd0);
    measure(len, hi);
    chk("R6 prescaler back", len, 10);

    // compare preload
    wr(2'd0, 16'b1001); wr(2'd2, 16'd3);
    measure(len, hi);
    wait_upd(); idle(5); wr(2'd2, 16'd7);
    chk("R7 buffered compare not yet active", int'(pwm), 0);
    wr(2'd0, 16'b1000); wr(2'd2, 16'd3);
    wait_upd(); idle(5); wr(2'd2, 16'd7);
    chk("R7 immediate compare active", int'(pwm), 1);

    // period preload
    wr(2'd2, 16'd4); wr(2'd0, 16'b1010);
    wait_upd(); idle(5); wr(2'd1, 16'd5);
    k = 0;
    do begin cyc(1'b0, 2'd0, 16'd0); k++; end while (!upd && k < 100);
    chk("R8 buffered period finishes old", k, 4);
    measure(len, hi);
    chk("R8 buffered period applied", len, 6);
    wr(2'd0, 16'b1000); wr(2'd1, 16'd9);
    wait_upd(); idle(5); wr(2'd1, 16'd3);
    k = 0;
    do begin cyc(1'b0, 2'd0, 16'd0); k++; end while (!upd && k < 100);
    chk("R8 immediate period wraps early", k, 1);

    // seeded random traffic, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) begin
        logic [1:0] a;
        logic [15:0] d;
        a = 2'($urandom % 4);
        case (a)
          2'd0: d = 16'($urandom % 16);
          2'd3: d = 16'($urandom % 4);
          default: d = 16'($urandom % 18);
        endcase
        wr(a, d);
      end else begin
        idle(1);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule